// File: doc/BRIEF.md
# Virtual Task-Priority Shadow Updater

This block handles guest writes to a shadowed task-priority register that lives in a virtual interrupt-controller page. Each accepted write stores a cleaned-up 32-bit word: the low byte keeps what the guest wrote and everything above it becomes zero. The block then compares the priority class, bits 7:4 of that byte, with a 4-bit threshold that the hypervisor programs. When the threshold is strictly higher, it asks for a VM exit.

A write that itself caused a VM exit is flagged by the surrounding logic. Such a write leaves the shadow untouched and starts no comparison. The interrupt-enable flag and the one-instruction interrupt shadow come into the block, but by design they never hold back an exit request. The request is a one-cycle pulse, one cycle after the write, and a fixed reason code goes with it.

Top module: `vtpr_shadow_unit`

## Requirements
- R1: Under a synchronous active-high `rst`, `tpr_word` becomes 0, `exit_req` becomes 0 and `exit_reason` reads 0.
- R2: After an accepted write (`wr_en`=1 and `wr_caused_exit`=0), bits 31:8 of `tpr_word` are 0, whatever was written there.
- R3: After an accepted write, bits 7:0 of `tpr_word` equal bits 7:0 of `wr_data`, which includes the low nibble 3:0 unchanged.
- R4: If a write is accepted in cycle N and `thr` is strictly greater than `wr_data[7:4]`, then `exit_req` is 1 in cycle N+1.
- R5: If a write is accepted in cycle N and `thr` is less than or equal to `wr_data[7:4]`, then `exit_req` is 0 in cycle N+1. Equal values do not request an exit.
- R6: A write presented with `wr_caused_exit`=1 leaves `tpr_word` unchanged and gives `exit_req`=0 in the next cycle.
- R7: `if_flag` and `irq_shadow` have no effect on `tpr_word` or `exit_req`. An exit is still requested when `if_flag`=0 or `irq_shadow`=1.
- R8: While `exit_req` is 1, `exit_reason` equals the parameter `EXIT_CODE` (default 16'h002B). While `exit_req` is 0, `exit_reason` is 0.
- R9: `exit_req` is a single-cycle pulse per write. With no write in cycle N, `exit_req` is 0 and `tpr_word` holds its value in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Guest write strobe for the shadow register |
| wr_data | input | 32 | Word the guest writes |
| thr | input | 4 | Programmed priority threshold |
| wr_caused_exit | input | 1 | The write itself caused a VM exit; skip the update |
| if_flag | input | 1 | Guest interrupt-enable flag (ignored) |
| irq_shadow | input | 1 | One-instruction interrupt shadow active (ignored) |
| tpr_word | output | 32 | Stored shadow register word |
| exit_req | output | 1 | One-cycle VM-exit request |
| exit_reason | output | 16 | Exit reason code, valid with `exit_req` |

## Verification
The bench builds the block with its default widths: a 32-bit word, a kept low byte and a 4-bit class and threshold. These small fields allow every threshold to be paired with every priority class, each pairing under four low-nibble values and all four combinations of the interrupt-enable and shadow inputs. The sweep covers the equal-value boundary and the extreme values 0 and 15 on both sides. It also writes varied garbage into the upper 24 bits. A second sweep repeats the pairings with the exit-caused flag set, to show that both the stored word and the exit output stay unmoved.

// File: rtl/vtpr_pkg.sv
package vtpr_pkg;

    // Default geometry of the shadowed priority register
    localparam int unsigned VTPR_WORD_W   = 32;
    localparam int unsigned VTPR_KEEP_W   = 8;
    localparam int unsigned VTPR_CLASS_W  = 4;
    localparam int unsigned VTPR_REASON_W = 16;
    localparam logic [VTPR_REASON_W-1:0] VTPR_EXIT_CODE = 16'h002B;

endpackage

// File: rtl/vtpr_sanitize.sv
// Keeps the low KEEP_W bits of a written word and zeroes the rest.
module vtpr_sanitize #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned KEEP_W = 8
) (
    input  logic [WORD_W-1:0] raw_word,
    output logic [WORD_W-1:0] clean_word
);
    localparam int unsigned DROP_W = WORD_W - KEEP_W;

    logic unused_dropped;

    generate
        if (DROP_W > 0) begin : g_drop
            assign clean_word     = {{DROP_W{1'b0}}, raw_word[KEEP_W-1:0]};
            assign unused_dropped = ^raw_word[WORD_W-1:KEEP_W];
        end else begin : g_keep_all
            assign clean_word     = raw_word;
            assign unused_dropped = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/vtpr_class_cmp.sv
// Strict greater-than of threshold against the priority class field.
module vtpr_class_cmp #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned KEEP_W    = 8,
    parameter int unsigned CLASS_W   = 4
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [CLASS_W-1:0] thr,
    output logic               thr_above
);
    localparam int unsigned CLASS_LSB = KEEP_W - CLASS_W;
    localparam int unsigned CLASS_MSB = KEEP_W - 1;

    logic [CLASS_W-1:0] prio_class;
    logic               unused_rest;

    assign prio_class  = word[CLASS_MSB:CLASS_LSB];
    assign thr_above   = (thr > prio_class);
    assign unused_rest = ^word;
endmodule

// File: rtl/vtpr_shadow_unit.sv
module vtpr_shadow_unit
    import vtpr_pkg::*;
#(
    parameter int unsigned WORD_W   = VTPR_WORD_W,
    parameter int unsigned KEEP_W   = VTPR_KEEP_W,
    parameter int unsigned CLASS_W  = VTPR_CLASS_W,
    parameter int unsigned REASON_W = VTPR_REASON_W,
    parameter logic [REASON_W-1:0] EXIT_CODE = VTPR_EXIT_CODE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [CLASS_W-1:0]  thr,
    input  logic                wr_caused_exit,
    input  logic                if_flag,
    input  logic                irq_shadow,
    output logic [WORD_W-1:0]   tpr_word,
    output logic                exit_req,
    output logic [REASON_W-1:0] exit_reason
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              exit_pend;
    } vtpr_state_t;

    vtpr_state_t st_d, st_q;

    logic [WORD_W-1:0] clean_word;
    logic              thr_above;
    logic              accept;
    logic              unused_masking;

    // Interrupt masking and shadowing deliberately take no part
    assign unused_masking = if_flag ^ irq_shadow;

    vtpr_sanitize #(
        .WORD_W (WORD_W),
        .KEEP_W (KEEP_W)
    ) u_sanitize (
        .raw_word   (wr_data),
        .clean_word (clean_word)
    );

    vtpr_class_cmp #(
        .WORD_W  (WORD_W),
        .KEEP_W  (KEEP_W),
        .CLASS_W (CLASS_W)
    ) u_cmp (
        .word      (clean_word),
        .thr       (thr),
        .thr_above (thr_above)
    );

    assign accept = wr_en && !wr_caused_exit;

    always_comb begin
        st_d           = st_q;
        st_d.exit_pend = 1'b0;
        if (accept) begin
            st_d.word      = clean_word;
            st_d.exit_pend = thr_above;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tpr_word    = st_q.word;
    assign exit_req    = st_q.exit_pend;
    assign exit_reason = st_q.exit_pend ? EXIT_CODE : '0;
endmodule

// File: rtl/vtpr_shadow_chk.sv
module vtpr_shadow_chk #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned KEEP_W   = 8,
    parameter int unsigned CLASS_W  = 4,
    parameter int unsigned REASON_W = 16,
    parameter logic [REASON_W-1:0] EXIT_CODE = 16'h002B
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [WORD_W-1:0]   wr_data,
    input logic [CLASS_W-1:0]  thr,
    input logic                wr_caused_exit,
    input logic [WORD_W-1:0]   tpr_word,
    input logic                exit_req,
    input logic [REASON_W-1:0] exit_reason
);
    localparam int unsigned CLASS_LSB = KEEP_W - CLASS_W;

    logic [CLASS_W-1:0] wr_class;
    logic               take;

    assign wr_class = wr_data[KEEP_W-1:CLASS_LSB];
    assign take     = wr_en && !wr_caused_exit;

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (tpr_word >> KEEP_W) == '0);

    // R3
    low_kept_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> tpr_word[KEEP_W-1:0] == $past(wr_data[KEEP_W-1:0]));

    // R4
    exit_above_chk: assert property (@(posedge clk) disable iff (rst)
        (take && thr > wr_class) |=> exit_req);

    // R5
    no_exit_low_chk: assert property (@(posedge clk) disable iff (rst)
        (take && thr <= wr_class) |=> !exit_req);

    // R6
    skip_caused_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_caused_exit) |=> (!exit_req && $stable(tpr_word)));

    // R8
    reason_chk: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> exit_reason == EXIT_CODE);

    // R8
    reason_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !exit_req |-> exit_reason == '0);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!exit_req && $stable(tpr_word)));
endmodule

bind vtpr_shadow_unit vtpr_shadow_chk #(
    .WORD_W    (WORD_W),
    .KEEP_W    (KEEP_W),
    .CLASS_W   (CLASS_W),
    .REASON_W  (REASON_W),
    .EXIT_CODE (EXIT_CODE)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .thr            (thr),
    .wr_caused_exit (wr_caused_exit),
    .tpr_word       (tpr_word),
    .exit_req       (exit_req),
    .exit_reason    (exit_reason)
);

// File: tb/vtpr_shadow_unit_bench.sv
`timescale 1ns/1ps
module vtpr_shadow_unit_bench;
    localparam logic [15:0] CODE = 16'h002B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  thr = '0;
    logic        wr_caused_exit = 1'b0;
    logic        if_flag = 1'b1;
    logic        irq_shadow = 1'b0;
    logic [31:0] tpr_word;
    logic        exit_req;
    logic [15:0] exit_reason;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] model_word = '0;

    always #2.5 clk = ~clk;

    vtpr_shadow_unit u_vtpr_shadow_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .thr(thr),
        .wr_caused_exit(wr_caused_exit), .if_flag(if_flag), .irq_shadow(irq_shadow),
        .tpr_word(tpr_word), .exit_req(exit_req), .exit_reason(exit_reason)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write, then one idle cycle; outputs sampled at falling edges
    task automatic write_once(input logic [31:0] d, input logic [3:0] t,
                              input logic caused, input logic ie, input logic sh);
        logic exp_exit;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; thr = t; wr_caused_exit = caused;
        if_flag = ie; irq_shadow = sh;
        exp_exit = !caused && (t > d[7:4]);
        if (!caused) model_word = {24'h0, d[7:0]};
        @(negedge clk);
        wr_en = 1'b0; wr_caused_exit = 1'b0;
        if (caused) begin
            chk("R6 word", tpr_word, model_word);
            chk("R6 exit", {31'h0, exit_req}, 32'h0);
        end else begin
            chk("R2 upper", {8'h0, tpr_word[31:8]}, 32'h0);
            chk("R3 low", {24'h0, tpr_word[7:0]}, {24'h0, d[7:0]});
            if (exp_exit) chk("R4 R7 exit", {31'h0, exit_req}, 32'h1);
            else          chk("R5 R7 exit", {31'h0, exit_req}, 32'h0);
        end
        chk("R8 reason", {16'h0, exit_reason}, exp_exit ? {16'h0, CODE} : 32'h0);
        @(negedge clk);
        chk("R9 pulse", {31'h0, exit_req}, 32'h0);
        chk("R9 hold", tpr_word, model_word);
        chk("R8 idle", {16'h0, exit_reason}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 word", tpr_word, 32'h0);
        chk("R1 exit", {31'h0, exit_req}, 32'h0);
        chk("R1 reason", {16'h0, exit_reason}, 32'h0);
        rst = 1'b0;
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int m = 0; m < 4; m++) begin
                        logic [3:0]  nib;
                        logic [23:0] hi;
                        nib = 4'(lo * 5);
                        hi  = 24'hA5C3F0 ^ 24'(t * 4099 + c * 257 + lo * 17 + m);
                        write_once({hi, 4'(c), nib}, 4'(t), 1'b0, m[0], m[1]);
                    end
                end
            end
        end
        // Exit-caused writes must leave everything alone
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                write_once({24'hFFFFFF, 4'(c), 4'(15 - c)}, 4'(t), 1'b1, 1'b0, 1'b1);
            end
        end
        // Reset after activity
        write_once(32'hDEAD_0037, 4'hF, 1'b0, 1'b0, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; model_word = '0;
        chk("R1 word after", tpr_word, 32'h0);
        chk("R1 exit after", {31'h0, exit_req}, 32'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule